// File: doc/BRIEF.md
# Palette Pixel Streamer

The streamer pulls 32-bit framebuffer words through a valid/ready word port. It slices each word into pixels of 4, 6, 8, 10 or 16 bits. For depths up to 10 bits, each pixel selects an entry of an internal palette, and the entry is presented on a valid/ready pixel port. At 16 bits the pixel is passed through unchanged.

The 6-bit and 10-bit depths come in two layouts:
- **Word-aligned:** whole pixels sit in each word and the spare top bits are dropped.
- **Bit-packed:** pixels run back to back across word boundaries. A bit collector joins the tail of one word to the head of the next.

The palette is one block of 16-bit cells. It is written a cell at a time. Depending on depth it is read as 32-bit entries (a pair of adjacent cells) or as single 16-bit entries.

A frame begins with a one-cycle start pulse. The pulse captures the format code and empties the collector. Display timing and pin assignment belong to other blocks.

Top module: `pal_pixel_streamer`

## Requirements
- R1: After reset, and until the first start pulse, `word_rdy_o` and `pix_vld_o` are low and word traffic has no effect.
- R2: A start pulse captures `fmt_i`, empties the collector and drops any pending output pixel. The first pixel afterwards begins at bit 0 of the next accepted word.
- R3: Pixels are taken from each word beginning at bit 0 and moving toward bit 31.
- R4: Format code 0 (4 bits) yields 8 pixels per word. For index e, the output is the 32-bit entry {cell[2e+1], cell[2e]}.
- R5: Format code 3 (8 bits) yields 4 pixels per word, using the same 32-bit entry view as R4.
- R6: Format code 1 (6 bits, word-aligned) yields 5 pixels per word, using the 32-bit entry view. Bits 31:30 of each word are dropped.
- R7: Format code 2 (6 bits, packed) treats the words as one continuous bit stream, so 3 words yield 16 pixels. Pixels may cross word boundaries. The 32-bit entry view is used.
- R8: Format code 4 (10 bits, word-aligned) yields 3 pixels per word. Bits 31:30 are dropped. The output is {16'h0, cell[index]}.
- R9: Format code 5 (10 bits, packed) treats the words as a continuous stream, so 5 words yield 16 pixels. The output is {16'h0, cell[index]}.
- R10: Format code 6 (and code 7) yields 2 raw 16-bit pixels per word, with output {16'h0, pixel} and no palette lookup.
- R11: When `pal_we_i` is high, `pal_wdata_i` is written to the cell at `pal_waddr_i`. A pixel whose lookup follows the write sees the new value. The lookup result appears one cycle after the pixel is taken, in the output register.
- R12: While `pix_vld_o` is high and `pix_rdy_i` is low, `pix_vld_o` and `pix_o` hold, and no pixel is lost.
- R13: `word_rdy_o` is high only when the collector holds fewer bits than one pixel needs. After a frame's last word, the leftover bits produce no pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Frame start pulse |
| fmt_i | input | 3 | Format code, captured at start |
| word_rdy_o | output | 1 | Streamer wants a word |
| word_vld_i | input | 1 | Word available |
| word_i | input | 32 | Framebuffer word |
| pal_we_i | input | 1 | Palette cell write enable |
| pal_waddr_i | input | PAL_AW | Palette cell address |
| pal_wdata_i | input | 16 | Palette cell data |
| pix_vld_o | output | 1 | Output pixel valid |
| pix_rdy_i | input | 1 | Sink ready |
| pix_o | output | 32 | Palette entry or raw pixel |

## Verification
The bench builds the streamer with the default `PAL_AW` of 10. This puts the full 1024-cell palette within reach, so 10-bit indices up to 1023 are looked up. It also means the 8-bit depth reaches paired cells up to 511. Every cell is loaded with a distinct computed value, so a wrong pairing or a wrong half shows in the output. Packed runs of 3 and 10 words push pixels across every possible split point of the 6-bit and 10-bit streams.

// File: rtl/pal_pixel_streamer.sv
`timescale 1ns/1ps
module pal_pixel_streamer #(
  parameter int PAL_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        fmt_i,
  output logic              word_rdy_o,
  input  logic              word_vld_i,
  input  logic [31:0]       word_i,
  input  logic              pal_we_i,
  input  logic [PAL_AW-1:0] pal_waddr_i,
  input  logic [15:0]       pal_wdata_i,
  output logic              pix_vld_o,
  input  logic              pix_rdy_i,
  output logic [31:0]       pix_o
);
  localparam int PAL_DEPTH = 1 << PAL_AW;
  localparam int ACC_W = 48;
  localparam int CNT_W = $clog2(ACC_W + 1);

  logic [15:0]       pal [PAL_DEPTH];
  logic [2:0]        fmt_q;
  logic              active;
  logic [ACC_W-1:0]  acc;
  logic [CNT_W-1:0]  cnt;
  logic [4:0]        pw;
  logic [31:0]       look;

  always_comb begin
    case (fmt_q)
      3'd0:       pw = 5'd4;
      3'd1, 3'd2: pw = 5'd6;
      3'd3:       pw = 5'd8;
      3'd4, 3'd5: pw = 5'd10;
      default:    pw = 5'd16;
    endcase
  end

  wire unpk       = (fmt_q == 3'd1) || (fmt_q == 3'd4);
  wire have       = cnt >= CNT_W'(pw);
  assign word_rdy_o = active && !have;
  wire take_word  = word_vld_i && word_rdy_o;
  wire take_pix   = active && have && (!pix_vld_o || pix_rdy_i);

  wire [15:0]       mask = 16'((17'd1 << pw) - 17'd1);
  wire [15:0]       idx  = acc[15:0] & mask;
  wire [PAL_AW-1:0] a_lo = PAL_AW'({idx, 1'b0});
  wire [PAL_AW-1:0] a_hi = PAL_AW'({idx, 1'b1});
  wire [PAL_AW-1:0] a_w  = PAL_AW'(idx);

  always_comb begin
    if (pw == 5'd16)      look = {16'h0, idx};
    else if (pw == 5'd10) look = {16'h0, pal[a_w]};
    else                  look = {pal[a_hi], pal[a_lo]};
  end

  always_ff @(posedge clk) begin
    if (pal_we_i) pal[pal_waddr_i] <= pal_wdata_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      fmt_q     <= 3'd0;
      acc       <= '0;
      cnt       <= '0;
      pix_vld_o <= 1'b0;
      pix_o     <= '0;
    end else if (start_i) begin
      active    <= 1'b1;
      fmt_q     <= fmt_i;
      acc       <= '0;
      cnt       <= '0;
      pix_vld_o <= 1'b0;
    end else begin
      if (take_word) begin
        if (unpk) begin
          acc <= ACC_W'(word_i);
          cnt <= CNT_W'(32);
        end else begin
          acc <= acc | (ACC_W'(word_i) << cnt);
          cnt <= cnt + CNT_W'(32);
        end
      end else if (take_pix) begin
        acc <= acc >> pw;
        cnt <= cnt - CNT_W'(pw);
      end
      if (take_pix) begin
        pix_vld_o <= 1'b1;
        pix_o     <= look;
      end else if (pix_rdy_i) begin
        pix_vld_o <= 1'b0;
      end
    end
  end

  a_r1_idle_before_start: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !word_rdy_o && !pix_vld_o);

  a_r2_start_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !pix_vld_o && cnt == '0);

  a_r12_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld_o && !pix_rdy_i && !start_i |=> pix_vld_o && $stable(pix_o));

  a_r13_collector_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(ACC_W - 1));

  // R8, R9, R10: no palette high half for 10-bit or raw pixels
  a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld_o && (fmt_q inside {3'd4, 3'd5, 3'd6, 3'd7}) |-> pix_o[31:16] == 16'h0);
endmodule

// File: tb/pal_pixel_streamer_tb_top.sv
`timescale 1ns/1ps
module pal_pixel_streamer_tb_top;
  localparam int PAL_AW = 10;
  localparam int NV = 10;
  localparam int VMODE [NV] = '{0, 3, 1, 2, 4, 5, 6, 7, 2, 5};
  localparam int VWORDS[NV] = '{2, 3, 3, 6, 3, 10, 3, 2, 3, 5};
  localparam int VPAT  [NV] = '{0, 0, 1, 0, 2, 0, 3, 0, 1, 2};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n = 1'b0, start_i = 1'b0, word_vld_i = 1'b0, pal_we_i = 1'b0, pix_rdy_i = 1'b1;
  logic [2:0]        fmt_i = 3'd0;
  logic [31:0]       word_i = '0;
  logic [PAL_AW-1:0] pal_waddr_i = '0;
  logic [15:0]       pal_wdata_i = '0;
  logic              word_rdy_o, pix_vld_o;
  logic [31:0]       pix_o;

  pal_pixel_streamer #(.PAL_AW(PAL_AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .fmt_i(fmt_i),
    .word_rdy_o(word_rdy_o), .word_vld_i(word_vld_i), .word_i(word_i),
    .pal_we_i(pal_we_i), .pal_waddr_i(pal_waddr_i), .pal_wdata_i(pal_wdata_i),
    .pix_vld_o(pix_vld_o), .pix_rdy_i(pix_rdy_i), .pix_o(pix_o));

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] palm [1024];
  logic [31:0] wbuf [16];

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic int pwid(int m);
    case (m)
      0: return 4; 1, 2: return 6; 3: return 8; 4, 5: return 10; default: return 16;
    endcase
  endfunction

  function automatic bit is_unpk(int m);
    return (m == 1) || (m == 4);
  endfunction

  function automatic string mtag(int m);
    case (m)
      0: return "R4"; 1: return "R6"; 2: return "R7"; 3: return "R5";
      4: return "R8"; 5: return "R9"; default: return "R10";
    endcase
  endfunction

  function automatic logic [31:0] expect_px(int m, int k);
    int p = pwid(m);
    int b;
    logic [15:0] ix = '0;
    for (int j = 0; j < p; j++) begin
      if (is_unpk(m)) b = (k / (32 / p)) * 32 + (k % (32 / p)) * p + j;
      else            b = k * p + j;
      ix[j] = wbuf[b / 32][b % 32];
    end
    if (p == 16) return {16'h0, ix};
    if (p == 10) return {16'h0, palm[ix]};
    return {palm[2 * ix + 1], palm[2 * ix]};
  endfunction

  task automatic pulse_start(int m);
    @(negedge clk);
    start_i = 1'b1; fmt_i = 3'(m);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_vec(int v);
    int m = VMODE[v], n = VWORDS[v], pat = VPAT[v];
    int p = pwid(m);
    int total = is_unpk(m) ? n * (32 / p) : (n * 32) / p;
    for (int i = 0; i < n; i++) wbuf[i] = (32'h9E3779B9 * 32'(v * 16 + i + 1)) ^ 32'h5A5A0FF0;
    pulse_start(m);
    fork
      begin
        for (int i = 0; i < n; i++) begin
          bit got;
          word_i = wbuf[i]; word_vld_i = 1'b1;
          do begin #1; got = word_rdy_o; @(negedge clk); end while (!got);
        end
        word_vld_i = 1'b0;
      end
      begin
        int k = 0, cyc = 0;
        while (k < total) begin
          pix_rdy_i = (pat == 0) || (cyc % (pat + 1) != 0);
          cyc++;
          #1;
          if (pix_vld_o && pix_rdy_i) begin
            logic [31:0] e = expect_px(m, k);
            chk(pix_o == e, $sformatf("%s R3 R11 fmt %0d pixel %0d", mtag(m), m, k), pix_o, e);
            k++;
          end
          @(negedge clk);
        end
        pix_rdy_i = 1'b1;
      end
    join
    repeat (3) @(negedge clk);
    #1;
    chk(!pix_vld_o, $sformatf("R13 %s no pixel from leftover bits", mtag(m)), 32'(pix_vld_o), 32'd0);
    chk(word_rdy_o, "R13 requests once below pixel width", 32'(word_rdy_o), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_sim();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!word_rdy_o, "R1 no request in reset", 32'(word_rdy_o), 32'd0);
    chk(!pix_vld_o, "R1 no pixel in reset", 32'(pix_vld_o), 32'd0);
    rst_n = 1'b1;
    pal_we_i = 1'b1;
    for (int a = 0; a < 1024; a++) begin
      @(negedge clk);
      pal_waddr_i = PAL_AW'(a);
      pal_wdata_i = 16'((a * 40503 + 16'h1357) ^ (a << 7));
      palm[a] = pal_wdata_i;
    end
    @(negedge clk);
    pal_we_i = 1'b0;
    word_vld_i = 1'b1; word_i = 32'h1234_5678;
    repeat (4) begin
      @(negedge clk); #1;
      chk(!word_rdy_o, "R1 word ignored before start", 32'(word_rdy_o), 32'd0);
      chk(!pix_vld_o, "R1 no pixel before start", 32'(pix_vld_o), 32'd0);
    end
    word_vld_i = 1'b0;

    for (int v = 0; v < NV; v++) run_vec(v);

    // R12 stall with raw 16-bit pixels
    pix_rdy_i = 1'b0;
    pulse_start(6);
    word_vld_i = 1'b1; word_i = 32'hBEEF_1234;
    @(negedge clk);
    word_vld_i = 1'b0;
    @(negedge clk);
    repeat (5) begin
      #1;
      chk(pix_vld_o && pix_o == 32'h0000_1234, "R12 stalled pixel held", pix_o, 32'h0000_1234);
      chk(!word_rdy_o, "R13 no request while a pixel is buffered", 32'(word_rdy_o), 32'd0);
      @(negedge clk);
    end
    pix_rdy_i = 1'b1;
    @(negedge clk); #1;
    chk(pix_vld_o && pix_o == 32'h0000_BEEF, "R12 second pixel after release", pix_o, 32'h0000_BEEF);
    pix_rdy_i = 1'b0;
    @(negedge clk);

    // R2 restart mid-frame with a pending output pixel
    pulse_start(0);
    #1;
    chk(!pix_vld_o, "R2 start drops pending pixel", 32'(pix_vld_o), 32'd0);
    chk(word_rdy_o, "R2 start empties collector", 32'(word_rdy_o), 32'd1);

    // R11 palette rewrite seen by later lookup
    @(negedge clk);
    pal_we_i = 1'b1; pal_waddr_i = 10'd10; pal_wdata_i = 16'hCAFE; palm[10] = 16'hCAFE;
    @(negedge clk);
    pal_waddr_i = 10'd11; pal_wdata_i = 16'hF00D; palm[11] = 16'hF00D;
    @(negedge clk);
    pal_we_i = 1'b0;
    pix_rdy_i = 1'b1;
    word_vld_i = 1'b1; word_i = 32'h0000_00A5;
    @(negedge clk);
    word_vld_i = 1'b0;
    @(negedge clk); #1;
    chk(pix_vld_o && pix_o == 32'hF00D_CAFE, "R2 R11 first pixel from bit 0 after restart",
        pix_o, 32'hF00D_CAFE);
    @(negedge clk); #1;
    chk(pix_vld_o && pix_o == {palm[21], palm[20]}, "R3 R4 second nibble", pix_o, {palm[21], palm[20]});
    repeat (10) @(negedge clk);
    finish_sim();
  end
endmodule